// File: doc/BRIEF.md
# Dynamic Loss Scale Controller

The block tracks a power-of-two loss scale for an iterative mixed-precision training loop. During an iteration it receives gradients as a stream of half-precision words, several lanes per cycle. It records whether any valid word is infinite or not a number. When the loop signals the end of an iteration, the block issues one decision. A commit pulse allows the weight update, and a skip pulse discards it. The block then moves the scale exponent to a new value.

An iteration that overflows halves the scale, which lowers the exponent by one. A run of clean iterations whose length equals a programmable window doubles the scale, which raises the exponent by one. The exponent never leaves a programmed lower and upper bound. With every commit the block also outputs the exponent that was in force during the committed iteration. The update path divides the gradients by 2^that exponent before it applies them. Software can load a start exponent, the two bounds and the window length at any time, which restarts the clean-run count.

A fixed scale is only safe while the scale times the largest gradient magnitude stays below 65504. This controller avoids choosing such a value by hand: it starts high and backs off whenever overflow appears.

Top module: `loss_scale_ctrl`

## Requirements
- R1: After synchronous reset, scale_exp and unscale_exp equal INIT_EXP (default 16), upd_commit and upd_skip are low, the clean-run count is zero and the window is WINDOW (default 2000).
- R2: A cycle with cfg_load high sets scale_exp to cfg_init_exp from the next cycle on. It stores cfg_min_exp, cfg_max_exp and cfg_window, clears the clean-run count and the overflow record, and produces no pulse.
- R3: A gradient word is non-finite when its bits [14:10] (the 5-bit exponent field) are all ones. Only lanes whose grad_vld bit is high are inspected. Lane i occupies grad_data[16*i+15:16*i].
- R4: An iteration end (iter_end high, cfg_load low) produces exactly one of upd_commit or upd_skip, high in the single following cycle only. No pulse appears without an iteration end.
- R5: An overflowed iteration gives upd_skip, lowers scale_exp by one unless it already equals the minimum bound, and clears the clean-run count.
- R6: A clean iteration gives upd_commit and adds one to the clean-run count. When the count reaches the window, scale_exp rises by one unless it already equals the maximum bound, and the count returns to zero in either case.
- R7: With each upd_commit, unscale_exp shows the scale exponent in force during the committed iteration. It holds that value through skips until the next commit.
- R8: Overflow is sticky from the first non-finite word to the iteration end. A word presented in the same cycle as iter_end belongs to the ending iteration. The next iteration starts with no overflow recorded.
- R9: A window value of zero behaves as a window of one.
- R10: cfg_load takes priority over iter_end in the same cycle, so that iteration end is discarded and no pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load start exponent, bounds and window |
| cfg_init_exp | input | EXP_W | Start scale exponent |
| cfg_min_exp | input | EXP_W | Lower exponent bound |
| cfg_max_exp | input | EXP_W | Upper exponent bound |
| cfg_window | input | WIN_W | Clean iterations needed before growth |
| grad_vld | input | LANES | Per-lane gradient valid |
| grad_data | input | 16*LANES | Half-precision gradient words, lane 0 in the low bits |
| iter_end | input | 1 | End-of-iteration strobe |
| upd_commit | output | 1 | Pulse: weight update allowed |
| upd_skip | output | 1 | Pulse: weight update skipped |
| scale_exp | output | EXP_W | Current loss scale exponent (scale = 2^scale_exp) |
| unscale_exp | output | EXP_W | Exponent of the committed iteration (unscale factor 2^-unscale_exp) |

## Verification
The bound properties assume that every loaded start exponent lies between the loaded bounds and that the minimum bound does not exceed the maximum. Without that, the halving and doubling checks could see a jump of more than one step. The stimulus only loads ordered triples and never drives cfg_load outside such a triple. A reference model in the bench is compared with the outputs every cycle. Directed iterations cover non-finite words in invalid lanes, in the same cycle as the strobe, and in both lanes. They also cover saturation at each bound, a zero window, and a load that collides with an iteration end.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int HALF_W = 16;
  localparam int FRAC_W = 10;
  localparam int EXPF_W = 5;

  typedef enum logic [1:0] {
    OUT_NONE   = 2'd0,
    OUT_COMMIT = 2'd1,
    OUT_SKIP   = 2'd2
  } iter_outcome_e;

  function automatic logic is_nonfinite(input logic [HALF_W-1:0] w);
    return &w[FRAC_W +: EXPF_W];
  endfunction
endpackage

// File: rtl/lsc_nf_scan.sv
module lsc_nf_scan #(
  parameter int LANES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clear,
  input  logic [LANES-1:0]              grad_vld,
  input  logic [LANES*lsc_pkg::HALF_W-1:0] grad_data,
  output logic                          ovf_iter
);
  import lsc_pkg::*;

  logic [LANES-1:0] lane_hit;
  logic             any_hit;
  logic             sticky_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_hit[i] = grad_vld[i] && is_nonfinite(grad_data[i*HALF_W +: HALF_W]);
  end

  assign any_hit  = |lane_hit;
  assign ovf_iter = sticky_q | any_hit;

  always_ff @(posedge clk) begin
    if (rst || clear) sticky_q <= 1'b0;
    else if (any_hit) sticky_q <= 1'b1;
  end
endmodule

// File: rtl/lsc_clean_ctr.sv
module lsc_clean_ctr #(
  parameter int WIN_W  = 16,
  parameter int WINDOW = 2000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIN_W-1:0] win_in,
  input  logic             step_clean,
  input  logic             step_ovf,
  output logic             reached
);
  localparam int CW = WIN_W + 1;

  logic [WIN_W-1:0] cnt_q;
  logic [WIN_W-1:0] win_q;
  logic [CW-1:0]    cnt_next;

  assign cnt_next = {1'b0, cnt_q} + CW'(1);
  assign reached  = cnt_next >= {1'b0, win_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      win_q <= WIN_W'(WINDOW);
    end else if (load) begin
      cnt_q <= '0;
      win_q <= win_in;
    end else if (step_ovf) begin
      cnt_q <= '0;
    end else if (step_clean) begin
      cnt_q <= reached ? '0 : cnt_next[WIN_W-1:0];
    end
  end
endmodule

// File: rtl/lsc_scale_reg.sv
module lsc_scale_reg #(
  parameter int EXP_W    = 6,
  parameter int INIT_EXP = 16,
  parameter int MIN_EXP  = 0,
  parameter int MAX_EXP  = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [EXP_W-1:0] init_in,
  input  logic [EXP_W-1:0] min_in,
  input  logic [EXP_W-1:0] max_in,
  input  logic             grow,
  input  logic             shrink,
  output logic [EXP_W-1:0] exp_o
);
  logic [EXP_W-1:0] exp_q, min_q, max_q;

  assign exp_o = exp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_q <= EXP_W'(INIT_EXP);
      min_q <= EXP_W'(MIN_EXP);
      max_q <= EXP_W'(MAX_EXP);
    end else if (load) begin
      exp_q <= init_in;
      min_q <= min_in;
      max_q <= max_in;
    end else if (shrink) begin
      if (exp_q > min_q) exp_q <= exp_q - EXP_W'(1);
    end else if (grow) begin
      if (exp_q < max_q) exp_q <= exp_q + EXP_W'(1);
    end
  end
endmodule

// File: rtl/loss_scale_ctrl.sv
module loss_scale_ctrl #(
  parameter int LANES    = 2,
  parameter int EXP_W    = 6,
  parameter int WIN_W    = 16,
  parameter int INIT_EXP = 16,
  parameter int MIN_EXP  = 0,
  parameter int MAX_EXP  = 40,
  parameter int WINDOW   = 2000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_load,
  input  logic [EXP_W-1:0]         cfg_init_exp,
  input  logic [EXP_W-1:0]         cfg_min_exp,
  input  logic [EXP_W-1:0]         cfg_max_exp,
  input  logic [WIN_W-1:0]         cfg_window,
  input  logic [LANES-1:0]         grad_vld,
  input  logic [LANES*16-1:0]      grad_data,
  input  logic                     iter_end,
  output logic                     upd_commit,
  output logic                     upd_skip,
  output logic [EXP_W-1:0]         scale_exp,
  output logic [EXP_W-1:0]         unscale_exp
);
  import lsc_pkg::*;

  logic          ovf_iter, win_reached, close_iter, do_skip, do_clean;
  iter_outcome_e outcome_q;
  logic [EXP_W-1:0] unscale_q;

  assign close_iter = iter_end && !cfg_load;
  assign do_skip    = close_iter && ovf_iter;
  assign do_clean   = close_iter && !ovf_iter;

  lsc_nf_scan #(.LANES(LANES)) u_scan (
    .clk      (clk),
    .rst      (rst),
    .clear    (iter_end || cfg_load),
    .grad_vld (grad_vld),
    .grad_data(grad_data),
    .ovf_iter (ovf_iter)
  );

  lsc_clean_ctr #(.WIN_W(WIN_W), .WINDOW(WINDOW)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .load      (cfg_load),
    .win_in    (cfg_window),
    .step_clean(do_clean),
    .step_ovf  (do_skip),
    .reached   (win_reached)
  );

  lsc_scale_reg #(
    .EXP_W(EXP_W), .INIT_EXP(INIT_EXP), .MIN_EXP(MIN_EXP), .MAX_EXP(MAX_EXP)
  ) u_scale (
    .clk    (clk),
    .rst    (rst),
    .load   (cfg_load),
    .init_in(cfg_init_exp),
    .min_in (cfg_min_exp),
    .max_in (cfg_max_exp),
    .grow   (do_clean && win_reached),
    .shrink (do_skip),
    .exp_o  (scale_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      outcome_q <= OUT_NONE;
      unscale_q <= EXP_W'(INIT_EXP);
    end else begin
      if (do_skip)       outcome_q <= OUT_SKIP;
      else if (do_clean) outcome_q <= OUT_COMMIT;
      else               outcome_q <= OUT_NONE;
      if (do_clean) unscale_q <= scale_exp;
    end
  end

  assign upd_commit  = (outcome_q == OUT_COMMIT);
  assign upd_skip    = (outcome_q == OUT_SKIP);
  assign unscale_exp = unscale_q;
endmodule

// File: rtl/loss_scale_ctrl_chk.sv
module loss_scale_ctrl_chk #(
  parameter int LANES = 2,
  parameter int EXP_W = 6
) (
  input logic                clk,
  input logic                rst,
  input logic                cfg_load,
  input logic [EXP_W-1:0]    cfg_init_exp,
  input logic [LANES-1:0]    grad_vld,
  input logic [LANES*16-1:0] grad_data,
  input logic                iter_end,
  input logic                upd_commit,
  input logic                upd_skip,
  input logic [EXP_W-1:0]    scale_exp,
  input logic [EXP_W-1:0]    unscale_exp
);
  logic [LANES-1:0] bad_lane;
  for (genvar i = 0; i < LANES; i++) begin : g_bad
    assign bad_lane[i] = grad_vld[i] && (grad_data[i*16+10 +: 5] == 5'b11111);
  end

  // R4
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(upd_commit && upd_skip));

  // R4
  pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_commit || upd_skip) |-> ($past(iter_end) && !$past(cfg_load)));

  // R2
  load_apply_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> (scale_exp == $past(cfg_init_exp)) && !upd_commit && !upd_skip);

  // R3
  same_cycle_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (iter_end && !cfg_load && (|bad_lane)) |=> upd_skip);

  // R5
  shrink_step_chk: assert property (@(posedge clk) disable iff (rst)
    upd_skip |-> (scale_exp == $past(scale_exp)) ||
                 (scale_exp == $past(scale_exp) - EXP_W'(1)));

  // R6
  grow_step_chk: assert property (@(posedge clk) disable iff (rst)
    upd_commit |-> (scale_exp == $past(scale_exp)) ||
                   (scale_exp == $past(scale_exp) + EXP_W'(1)));

  // R7
  unscale_match_chk: assert property (@(posedge clk) disable iff (rst)
    upd_commit |-> (unscale_exp == $past(scale_exp)));

  // R7
  unscale_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_commit |-> $stable(unscale_exp));
endmodule

bind loss_scale_ctrl loss_scale_ctrl_chk #(.LANES(LANES), .EXP_W(EXP_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_load    (cfg_load),
  .cfg_init_exp(cfg_init_exp),
  .grad_vld    (grad_vld),
  .grad_data   (grad_data),
  .iter_end    (iter_end),
  .upd_commit  (upd_commit),
  .upd_skip    (upd_skip),
  .scale_exp   (scale_exp),
  .unscale_exp (unscale_exp)
);

// File: tb/sim_loss_scale_ctrl.sv
`timescale 1ns/1ps
module sim_loss_scale_ctrl;
  localparam int LANES = 2, EXP_W = 6, WIN_W = 16;
  localparam int INIT = 16, MINE = 0, MAXE = 40, WIN = 2000;

  logic clk = 0, rst = 1, cfg_load = 0, iter_end = 0;
  logic [EXP_W-1:0] cfg_init_exp = 0, cfg_min_exp = 0, cfg_max_exp = 0;
  logic [WIN_W-1:0] cfg_window = 0;
  logic [LANES-1:0] grad_vld = 0;
  logic [LANES*16-1:0] grad_data = 0;
  logic upd_commit, upd_skip;
  logic [EXP_W-1:0] scale_exp, unscale_exp;

  always #2 clk = ~clk;

  loss_scale_ctrl u0 (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  int m_exp, m_cnt, m_un, m_min, m_max, m_win;
  bit m_sticky, m_c, m_s;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit word_bad(input logic [15:0] w);
    return ((w >> 10) & 16'h1f) == 16'h1f;
  endfunction

  task automatic model_step();
    bit hit, ovf;
    if (rst) begin
      m_exp = INIT; m_un = INIT; m_cnt = 0; m_sticky = 0; m_c = 0; m_s = 0;
      m_min = MINE; m_max = MAXE; m_win = WIN;
    end else if (cfg_load) begin
      m_exp = cfg_init_exp; m_min = cfg_min_exp; m_max = cfg_max_exp;
      m_win = cfg_window; m_cnt = 0; m_sticky = 0; m_c = 0; m_s = 0;
    end else begin
      hit = 0;
      for (int i = 0; i < LANES; i++)
        if (grad_vld[i] && word_bad(grad_data[i*16 +: 16])) hit = 1;
      ovf = m_sticky | hit;
      m_c = 0; m_s = 0;
      if (iter_end) begin
        if (ovf) begin
          m_s = 1; m_cnt = 0;
          if (m_exp > m_min) m_exp--;
        end else begin
          m_c = 1; m_un = m_exp; m_cnt++;
          if (m_cnt >= m_win) begin
            m_cnt = 0;
            if (m_exp < m_max) m_exp++;
          end
        end
        m_sticky = 0;
      end else m_sticky = ovf;
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    model_step();
    chk(scale_exp == EXP_W'(m_exp), "R6 scale_exp vs model", scale_exp, m_exp);
    chk(upd_commit == m_c && upd_skip == m_s, "R4 pulses vs model",
        {upd_commit, upd_skip}, {m_c, m_s});
    chk(unscale_exp == EXP_W'(m_un), "R7 unscale_exp vs model", unscale_exp, m_un);
    @(negedge clk);
    cfg_load = 0; iter_end = 0; grad_vld = 0;
  endtask

  function automatic logic [15:0] fin_word();
    logic [15:0] w = 16'($urandom);
    if (w[14:10] == 5'b11111) w[14] = 1'b0;
    return w;
  endfunction

  task automatic grads(input int n);
    for (int k = 0; k < n; k++) begin
      grad_vld = LANES'($urandom) | 1;
      grad_data = {fin_word(), fin_word()};
      cyc();
    end
  endtask

  task automatic close_clean();
    grad_vld = 2'b11; grad_data = {fin_word(), fin_word()}; iter_end = 1; cyc();
  endtask

  task automatic load(input int ie, input int mn, input int mx, input int w);
    cfg_load = 1; cfg_init_exp = EXP_W'(ie); cfg_min_exp = EXP_W'(mn);
    cfg_max_exp = EXP_W'(mx); cfg_window = WIN_W'(w); cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc(); cyc();
    rst = 0;
    // R1 reset state
    chk(scale_exp == 16 && unscale_exp == 16 && !upd_commit && !upd_skip,
        "R1 reset state", scale_exp, 16);
    // R6 default window of 2000 clean iterations
    for (int k = 0; k < 1999; k++) close_clean();
    chk(scale_exp == 16, "R6 before window end", scale_exp, 16);
    close_clean();
    chk(scale_exp == 17 && upd_commit, "R6 grow at window 2000", scale_exp, 17);
    // R2 load
    load(10, 8, 12, 3);
    chk(scale_exp == 10 && !upd_commit && !upd_skip, "R2 load applied", scale_exp, 10);
    grads(4); close_clean();
    chk(upd_commit && unscale_exp == 10, "R7 commit carries exponent", unscale_exp, 10);
    cyc();
    chk(!upd_commit && !upd_skip, "R4 single-cycle pulse", upd_commit, 0);
    grads(2); close_clean(); close_clean();
    chk(scale_exp == 11, "R6 grow after 3 clean", scale_exp, 11);
    // R3/R8 sticky overflow mid-iteration
    grad_vld = 2'b01; grad_data = {16'h3c00, 16'h7c00}; cyc();
    grads(3); close_clean();
    chk(upd_skip && scale_exp == 10, "R5 skip halves scale", scale_exp, 10);
    chk(unscale_exp == 10, "R7 unscale held over skip", unscale_exp, 10);
    // R3 invalid lane ignored
    grad_vld = 2'b01; grad_data = {16'h7e00, 16'h3c00}; iter_end = 1; cyc();
    chk(upd_commit && scale_exp == 10, "R3 invalid lane ignored", upd_commit, 1);
    // R8 same-cycle word belongs to ending iteration
    grad_vld = 2'b10; grad_data = {16'hfe01, 16'h0001}; iter_end = 1; cyc();
    chk(upd_skip && scale_exp == 9, "R8 same-cycle NaN skips", scale_exp, 9);
    grads(2); close_clean();
    chk(upd_commit, "R8 sticky cleared for next iteration", upd_commit, 1);
    // R5 min saturation
    grad_vld = 2'b11; grad_data = {16'hfc00, 16'h7c00}; iter_end = 1; cyc();
    grad_vld = 2'b01; grad_data = {16'h0, 16'h7fff}; iter_end = 1; cyc();
    chk(upd_skip && scale_exp == 8, "R5 saturate at minimum", scale_exp, 8);
    // R9 window zero acts as one; R6 max saturation
    load(11, 8, 12, 0);
    close_clean();
    chk(scale_exp == 12, "R9 window zero grows each clean", scale_exp, 12);
    close_clean();
    chk(scale_exp == 12 && upd_commit, "R6 saturate at maximum", scale_exp, 12);
    // R10 load beats iter_end
    cfg_load = 1; cfg_init_exp = 6'd20; cfg_min_exp = 6'd2; cfg_max_exp = 6'd30;
    cfg_window = 16'd2; iter_end = 1; grad_vld = 2'b01; grad_data = {16'h0, 16'h7c00};
    cyc();
    chk(scale_exp == 20 && !upd_commit && !upd_skip, "R10 load priority", scale_exp, 20);
    close_clean(); close_clean();
    chk(scale_exp == 21, "R2 window loaded as 2", scale_exp, 21);
    cyc();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule